// File: doc/BRIEF.md
# CPU Hotplug Presence and GPE Notifier

This block keeps a record of which processors are present, one bit for each processor ID. It also raises a level-sensitive system control interrupt (SCI) whenever a processor is added or removed. Firmware reads the record one byte at a time through a byte-wide I/O port. The bit for processor `id` sits in byte `id/8` at bit position `id%8`.

A processor add or remove strobe updates the record and also latches a CPU-hotplug flag in a general-purpose event (GPE) status byte. A separate PCI-hotplug strobe latches its own flag in the same byte. The SCI stays asserted while either flag is set and its matching enable bit is set. Firmware services the interrupt by reading the record and then clearing the flag with a write-one-to-clear access.

The record is loaded from a preset vector during reset, so processors that are present at power-up appear before any event arrives.

Top module: `cpu_hotplug_gpe`

## Requirements
- R1: While `rst_ni` is low and after it rises: the presence record equals `preset_i`, all GPE status and enable bits are 0, `sci_o` is 0 and `io_rdata_o` is 0x00.
- R2: A read (`io_rd_i`) at address 0xAF00+k, for k = 0 to 31, returns presence bits [8k+7:8k] on `io_rdata_o` one cycle later. `io_rdata_o` holds its value in cycles with no read.
- R3: A valid event with `evt_add_i`=1 sets the bit of `evt_id_i` (byte `id/8`, bit `id%8`). A valid event with `evt_add_i`=0 clears that bit. The change is visible from the next cycle.
- R4: Writes to 0xAF00..0xAF1F have no effect on the presence record.
- R5: Every valid event with an in-range ID sets status bit 2 (mask 0x04) of the status byte at 0xAFE0. A `pci_evt_i` pulse sets bit 1 (mask 0x02) of that byte.
- R6: Status bytes (0xAFE0, 0xAFE1) clear the bits written as 1 and keep the rest. Enable bytes (0xAFE2, 0xAFE3) are plain read/write. All four read back at their addresses.
- R7: If a status clear of a bit and an event that sets the same bit fall in the same cycle, the bit stays set.
- R8: An event with `evt_id_i` >= 256 changes neither the presence record nor the GPE status.
- R9: `sci_o` is 1 exactly when (status byte 0 AND enable byte 0) AND 0x06 is non-zero. It tracks the registered state with no added delay.
- R10: A read at any address outside 0xAF00..0xAF1F and 0xAFE0..0xAFE3 returns 0xFF one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O port address |
| io_rd_i | input | 1 | Byte read strobe |
| io_wr_i | input | 1 | Byte write strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Registered read data |
| evt_valid_i | input | 1 | Processor hotplug event strobe |
| evt_add_i | input | 1 | 1 = add, 0 = remove |
| evt_id_i | input | 9 | Processor ID of the event |
| pci_evt_i | input | 1 | PCI hotplug event strobe |
| preset_i | input | 256 | Processors present at reset |
| sci_o | output | 1 | Level-sensitive interrupt request |

## Verification
A wrong bit in the presence record stays hidden until firmware reads its byte. The bench therefore reads back the affected byte in the cycle after every targeted event, and each read shows up on `io_rdata_o` one cycle later. A wrongly latched or wrongly cleared GPE status bit shows up on `sci_o` in the very next cycle, as long as its enable bit is set. Tests run with the enables both set and clear, so a status error is also caught through a direct read of 0xAFE0. A behavioural model compares both outputs on every clock. Corner cases are covered by targeted tests and by a long mixed random run: an out-of-range ID, an event that collides with a clear in the same cycle, and edge bytes of the record.

// File: rtl/cphp_pkg.sv
package cphp_pkg;
  localparam int          GPE_PCI_BIT   = 1;
  localparam int          GPE_CPU_BIT   = 2;
  localparam logic [7:0]  SCI_MASK      = 8'h06;
  localparam logic [7:0]  UNMAPPED_DATA = 8'hFF;
endpackage

// File: rtl/cphp_presence_map.sv
module cphp_presence_map #(
  parameter int MAP_BITS = 256,
  localparam int IDX_W   = $clog2(MAP_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MAP_BITS-1:0] preset_i,
  input  logic                upd_i,
  input  logic                set_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [MAP_BITS-1:0] map_o
);
  logic [MAP_BITS-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    map_q <= preset_i;
    else if (upd_i) map_q[idx_i] <= set_i;
  end

  assign map_o = map_q;

  AST_ADD_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && set_i |=> map_q[$past(idx_i)]); // R3
  AST_REMOVE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !set_i |=> !map_q[$past(idx_i)]); // R3
  AST_MAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(map_q)); // R4
endmodule

// File: rtl/cphp_gpe_regs.sv
module cphp_gpe_regs
  import cphp_pkg::*;
#(
  parameter int GPE_HALF = 2,
  localparam int OFF_W   = $clog2(2*GPE_HALF),
  localparam int HW      = GPE_HALF*8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       wdata_i,
  input  logic             cpu_evt_i,
  input  logic             pci_evt_i,
  output logic [HW-1:0]    sts_o,
  output logic [HW-1:0]    en_o,
  output logic             sci_o
);
  logic [HW-1:0] sts_q, sts_d, en_q, en_d;
  logic [OFF_W-2:0] hsel;
  logic is_en;

  assign hsel  = off_i[OFF_W-2:0];
  assign is_en = off_i[OFF_W-1];

  always_comb begin
    sts_d = sts_q;
    en_d  = en_q;
    if (wr_i) begin
      if (is_en) en_d[{hsel, 3'b000} +: 8] = wdata_i;
      else       sts_d[{hsel, 3'b000} +: 8] = sts_q[{hsel, 3'b000} +: 8] & ~wdata_i;
    end
    // set sources override a same-cycle clear
    if (pci_evt_i) sts_d[GPE_PCI_BIT] = 1'b1;
    if (cpu_evt_i) sts_d[GPE_CPU_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign sci_o = |(sts_q[7:0] & en_q[7:0] & SCI_MASK);

  AST_CPU_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_evt_i |=> sts_q[GPE_CPU_BIT]); // R7
  AST_PCI_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_evt_i |=> sts_q[GPE_PCI_BIT]); // R5
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_q)); // R6
  AST_SCI_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q[7:0] & SCI_MASK) == 8'h00) |-> !sci_o); // R9
endmodule

// File: rtl/cpu_hotplug_gpe.sv
module cpu_hotplug_gpe
  import cphp_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] MAP_BASE = 'hAF00,
  parameter int               MAP_BYTES = 32,
  parameter logic [ADDR_W-1:0] GPE_BASE = 'hAFE0,
  parameter int               GPE_HALF  = 2,
  parameter int               ID_W      = 9,
  localparam int              MAP_BITS  = MAP_BYTES*8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   io_addr_i,
  input  logic                io_rd_i,
  input  logic                io_wr_i,
  input  logic [7:0]          io_wdata_i,
  output logic [7:0]          io_rdata_o,
  input  logic                evt_valid_i,
  input  logic                evt_add_i,
  input  logic [ID_W-1:0]     evt_id_i,
  input  logic                pci_evt_i,
  input  logic [MAP_BITS-1:0] preset_i,
  output logic                sci_o
);
  localparam int IDX_W  = $clog2(MAP_BITS);
  localparam int OFF_W  = $clog2(MAP_BYTES);
  localparam int GOFF_W = $clog2(2*GPE_HALF);
  localparam int HW     = GPE_HALF*8;

  logic [ADDR_W-1:0]   map_off, gpe_off;
  logic                in_map, in_gpe, evt_ok;
  logic [MAP_BITS-1:0] map_w;
  logic [HW-1:0]       sts_w, en_w;
  logic [7:0]          rd_d, rdata_q;

  assign map_off = io_addr_i - MAP_BASE;
  assign gpe_off = io_addr_i - GPE_BASE;
  assign in_map  = map_off < ADDR_W'(MAP_BYTES);
  assign in_gpe  = gpe_off < ADDR_W'(2*GPE_HALF);
  assign evt_ok  = evt_valid_i && (evt_id_i < ID_W'(MAP_BITS));

  cphp_presence_map #(.MAP_BITS(MAP_BITS)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (preset_i),
    .upd_i    (evt_ok),
    .set_i    (evt_add_i),
    .idx_i    (evt_id_i[IDX_W-1:0]),
    .map_o    (map_w)
  );

  cphp_gpe_regs #(.GPE_HALF(GPE_HALF)) u_gpe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (io_wr_i && in_gpe),
    .off_i     (gpe_off[GOFF_W-1:0]),
    .wdata_i   (io_wdata_i),
    .cpu_evt_i (evt_ok),
    .pci_evt_i (pci_evt_i),
    .sts_o     (sts_w),
    .en_o      (en_w),
    .sci_o     (sci_o)
  );

  always_comb begin
    rd_d = UNMAPPED_DATA;
    if (in_map)
      rd_d = map_w[{map_off[OFF_W-1:0], 3'b000} +: 8];
    else if (in_gpe) begin
      if (gpe_off[GOFF_W-1]) rd_d = en_w[{gpe_off[GOFF_W-2:0], 3'b000} +: 8];
      else                   rd_d = sts_w[{gpe_off[GOFF_W-2:0], 3'b000} +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= 8'h00;
    else if (io_rd_i) rdata_q <= rd_d;
  end

  assign io_rdata_o = rdata_q;

  AST_OOB_MAP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && (evt_id_i >= ID_W'(MAP_BITS)) |=> $stable(map_w)); // R8
  AST_UNMAPPED_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && !in_map && !in_gpe |=> io_rdata_o == UNMAPPED_DATA); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |=> $stable(io_rdata_o)); // R2
endmodule

// File: tb/tb_cpu_hotplug_gpe.sv
module tb_cpu_hotplug_gpe;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [15:0]  io_addr = '0;
  logic         io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]   io_wdata = '0;
  logic [7:0]   io_rdata;
  logic         evt_valid = 1'b0, evt_add = 1'b0, pci_evt = 1'b0;
  logic [8:0]   evt_id = '0;
  logic [255:0] preset;
  logic         sci;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  logic [255:0] m_map;
  logic [15:0]  m_sts, m_en;
  logic [7:0]   m_rd;

  always #4 clk = ~clk;

  cpu_hotplug_gpe dut (
    .clk_i(clk), .rst_ni(rst_ni), .io_addr_i(io_addr), .io_rd_i(io_rd),
    .io_wr_i(io_wr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .evt_valid_i(evt_valid), .evt_add_i(evt_add), .evt_id_i(evt_id),
    .pci_evt_i(pci_evt), .preset_i(preset), .sci_o(sci)
  );

  function automatic logic [7:0] model_read(logic [15:0] a);
    int o;
    if (a >= 16'hAF00 && a < 16'hAF20) begin
      o = int'(a - 16'hAF00);
      return m_map[o*8 +: 8];
    end
    case (a)
      16'hAFE0: return m_sts[7:0];
      16'hAFE1: return m_sts[15:8];
      16'hAFE2: return m_en[7:0];
      16'hAFE3: return m_en[15:8];
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, update model, compare both outputs
  task automatic step(bit rd, bit wr, logic [15:0] a, logic [7:0] wd,
                      bit ev, bit add, logic [8:0] id, bit pci, string tag);
    logic exp_sci;
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata = wd;
    evt_valid = ev; evt_add = add; evt_id = id; pci_evt = pci;
    if (rd) m_rd = model_read(a);
    if (wr) begin
      case (a)
        16'hAFE0: m_sts[7:0]  = m_sts[7:0]  & ~wd;
        16'hAFE1: m_sts[15:8] = m_sts[15:8] & ~wd;
        16'hAFE2: m_en[7:0]   = wd;
        16'hAFE3: m_en[15:8]  = wd;
        default: ;
      endcase
    end
    if (pci) m_sts[1] = 1'b1;
    if (ev && id < 9'd256) begin
      m_map[id[7:0]] = add;
      m_sts[2] = 1'b1;
    end
    exp_sci = ((m_sts[7:0] & m_en[7:0] & 8'h06) != 8'h00);
    @(posedge clk);
    @(negedge clk);
    check(tag, io_rdata, m_rd, "rdata");
    check(tag, {7'b0, sci}, {7'b0, exp_sci}, "sci");
  endtask

  task automatic rd_at(logic [15:0] a, string tag);
    step(1, 0, a, 8'h00, 0, 0, 9'd0, 0, tag);
  endtask

  task automatic wr_at(logic [15:0] a, logic [7:0] d, string tag);
    step(0, 1, a, d, 0, 0, 9'd0, 0, tag);
  endtask

  task automatic evt(bit add, logic [8:0] id, string tag);
    step(0, 0, 16'h0000, 8'h00, 1, add, id, 0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) preset[i] = (i % 3 == 0) || (i == 200);
    m_map = preset; m_sts = '0; m_en = '0; m_rd = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", io_rdata, 8'h00, "rdata in reset");
    check("R1", {7'b0, sci}, 8'h00, "sci in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", io_rdata, 8'h00, "rdata after reset");
    check("R1", {7'b0, sci}, 8'h00, "sci after reset");
    // R1/R2: preset visible on every byte
    for (int k = 0; k < 32; k++) rd_at(16'hAF00 + 16'(k), "R2");
    for (int k = 0; k < 4; k++) rd_at(16'hAFE0 + 16'(k), "R1");
    // R2: hold with no read
    step(0, 0, 16'hAF03, 8'h00, 0, 0, 9'd0, 0, "R2");
    // R4: writes to the record ignored
    wr_at(16'hAF00, 8'hFF, "R4");
    wr_at(16'hAF1F, 8'h00, "R4");
    rd_at(16'hAF00, "R4");
    rd_at(16'hAF1F, "R4");
    // R3/R5: add and remove at edge IDs
    evt(1, 9'd1, "R3");
    rd_at(16'hAF00, "R3");
    rd_at(16'hAFE0, "R5");
    evt(0, 9'd0, "R3");
    rd_at(16'hAF00, "R3");
    evt(1, 9'd254, "R3");
    evt(0, 9'd255, "R3");
    rd_at(16'hAF1F, "R3");
    evt(1, 9'd255, "R3");
    rd_at(16'hAF1F, "R3");
    // R9: enables gate the interrupt
    wr_at(16'hAFE2, 8'h01, "R9");
    wr_at(16'hAFE2, 8'h04, "R9");
    wr_at(16'hAFE3, 8'hA5, "R6");
    rd_at(16'hAFE3, "R6");
    // R6: clear
    wr_at(16'hAFE0, 8'h04, "R6");
    rd_at(16'hAFE0, "R6");
    step(0, 0, 16'h0, 8'h0, 0, 0, 9'd0, 1, "R5");
    wr_at(16'hAFE2, 8'h02, "R9");
    rd_at(16'hAFE0, "R5");
    wr_at(16'hAFE0, 8'h02, "R6");
    // R7: set wins over same-cycle clear
    wr_at(16'hAFE2, 8'h06, "R9");
    step(0, 1, 16'hAFE0, 8'h06, 1, 1, 9'd77, 0, "R7");
    rd_at(16'hAFE0, "R7");
    step(0, 1, 16'hAFE0, 8'h06, 0, 0, 9'd0, 1, "R7");
    rd_at(16'hAFE0, "R7");
    wr_at(16'hAFE0, 8'hFF, "R6");
    // R8: out-of-range IDs ignored
    evt(1, 9'd256, "R8");
    evt(0, 9'd300, "R8");
    evt(1, 9'd511, "R8");
    rd_at(16'hAFE0, "R8");
    for (int k = 0; k < 32; k++) rd_at(16'hAF00 + 16'(k), "R8");
    // R10: unmapped reads
    rd_at(16'hAEFF, "R10");
    rd_at(16'hAF20, "R10");
    rd_at(16'hAFDF, "R10");
    rd_at(16'hAFE4, "R10");
    rd_at(16'h0000, "R10");
    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      int sel = $urandom_range(0, 3);
      a = (sel == 0) ? 16'hAF00 + 16'($urandom_range(0, 31)) :
          (sel == 1) ? 16'hAFE0 + 16'($urandom_range(0, 3)) :
          (sel == 2) ? 16'hAF00 + 16'($urandom_range(0, 255)) : 16'($urandom);
      step(bit'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0), a, 8'($urandom),
           ($urandom_range(0, 2) == 0), bit'($urandom_range(0, 1)),
           9'($urandom_range(0, 300)), ($urandom_range(0, 7) == 0), "R3");
    end
    finish_run();
  end
endmodule